// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Acknowledge

This block joins a row of identical device interrupt cells into one priority chain. Each cell remembers a request from its device. All cells share a single interrupt line toward the processor, which is high while any cell holds a pending request. The processor answers with one acknowledge level that enters cell 0. The acknowledge then ripples cell by cell. A cell with nothing pending passes it on. The first cell holding a request keeps the acknowledge from travelling any further and puts its own identifier on the vector lines. The processor can then branch straight to that device's service routine, without polling every device.

Priority comes only from position in the chain: cell 0 is nearest the processor and has the highest priority. The set of cells that can block is sampled in the first cycle of an acknowledge and stays fixed until the acknowledge ends. A request that arrives mid-acknowledge therefore cannot take the vector away from the cell that already won. If no cell claims the acknowledge, a spurious flag is raised and the vector reads zero. The vector output is a plain registered word with no back-pressure. It is valid from the first clock edge after the acknowledge rises, and it holds steady for as long as the processor keeps the acknowledge high.

Top module: `irq_daisy_chain`

## Requirements
- R1: While rst_n is low and right after reset, irq_out, vec_out and spurious_out are all 0 and no cell is pending.
- R2: A one-cycle pulse on dev_req[k] makes cell k pending, and irq_out is high from the next clock edge until every pending request has been served.
- R3: On the first clock edge at which ack_in is high, vec_out becomes VEC_BASE + k, where k is the lowest-numbered cell pending before that edge (0x20 + k with the defaults).
- R4: While ack_in stays high, vec_out and spurious_out keep their values, even when a higher-priority cell becomes pending during the acknowledge.
- R5: On the first edge with ack_in low after an acknowledge, the winning cell stops being pending, every other cell keeps its request, and vec_out returns to 0.
- R6: When no cell is pending as the acknowledge starts, spurious_out is 1 and vec_out is 0 for the whole acknowledge, and no pending state changes.
- R7: A dev_req pulse to the winning cell in the cycle its request would be cleared leaves that cell pending.
- R8: After an edge at which ack_in was low, vec_out is 0 and spurious_out is 0; vec_out is never nonzero while spurious_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_CELLS | Per-device request pulses; bit 0 has the highest priority |
| irq_out | output | 1 | Shared interrupt line, OR of all pending requests |
| ack_in | input | 1 | Processor acknowledge, held high for one acknowledge cycle |
| vec_out | output | VEC_W | Winning cell's vector, 0 when idle or spurious |
| spurious_out | output | 1 | Acknowledge passed the chain tail unclaimed |

## Verification
A wrong pending bit shows up on irq_out one edge after the pulse that should have set it, or as a vector from the wrong cell at the next acknowledge. A broken pass-through or block shows up as a lower-priority vector, or as a spurious flag, on the first edge of the acknowledge. Losing the snapshot taken at the start of the acknowledge shows up as a vector that changes within an acknowledge. A wrong clear shows up at the next acknowledge, which returns the same cell again or skips a cell that was still pending.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  // Identifier returned by chain cell idx; zero is kept for "nobody answered".
  function automatic logic [31:0] cell_vector(input int unsigned base, input int unsigned idx);
    return 32'(base + idx);
  endfunction

endpackage

// File: rtl/irq_ack_seq.sv
// Tracks the phase of the processor acknowledge: its first cycle and the
// cycle after it ends. The cells use these to freeze and release their claims.
module irq_ack_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  output logic ack_first,
  output logic ack_last
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_in;
  end

  assign ack_first = ack_in & ~ack_q;
  assign ack_last  = ~ack_in & ack_q;
endmodule

// File: rtl/irq_cell.sv
// One link of the chain: request latch, acknowledge block/pass and vector drive.
module irq_cell #(
  parameter int unsigned        VEC_W    = 8,
  parameter logic [VEC_W-1:0]   CELL_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_set,
  input  logic             ack_first,
  input  logic             ack_last,
  input  logic             ack_in,
  output logic             ack_out,
  output logic             req_out,
  output logic [VEC_W-1:0] vec_out
);
  logic pend_q;
  logic hold_q;
  logic win_q;
  logic block;
  logic win;

  // In the first cycle the live request decides; afterwards the snapshot does.
  assign block   = ack_first ? pend_q : hold_q;
  assign ack_out = ack_in & ~block;
  assign win     = ack_in & block;
  assign vec_out = win ? CELL_VEC : '0;
  assign req_out = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      if (dev_set)                pend_q <= 1'b1;
      else if (ack_last && win_q) pend_q <= 1'b0;

      if (ack_first)     hold_q <= pend_q;
      else if (ack_last) hold_q <= 1'b0;

      win_q <= win;
    end
  end
endmodule

// File: rtl/irq_vec_merge.sv
// OR-combines the per-cell vector words and registers the result together
// with the chain-tail flag.
module irq_vec_merge #(
  parameter int unsigned N_CELLS = 8,
  parameter int unsigned VEC_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_CELLS-1:0][VEC_W-1:0] cell_vec,
  input  logic                          tail_ack,
  output logic [VEC_W-1:0]              vec_q,
  output logic                          spur_q
);
  logic [N_CELLS:0][VEC_W-1:0] acc;

  assign acc[0] = '0;
  for (genvar i = 0; i < N_CELLS; i++) begin : g_or
    assign acc[i+1] = acc[i] | cell_vec[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      spur_q <= 1'b0;
    end else begin
      vec_q  <= acc[N_CELLS];
      spur_q <= tail_ack;
    end
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int unsigned N_CELLS  = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CELLS-1:0] dev_req,
  output logic               irq_out,
  input  logic               ack_in,
  output logic [VEC_W-1:0]   vec_out,
  output logic               spurious_out
);
  import irq_chain_pkg::*;

  logic                          ack_first;
  logic                          ack_last;
  logic [N_CELLS:0]              chain;
  logic [N_CELLS-1:0]            pend;
  logic [N_CELLS-1:0][VEC_W-1:0] cell_vec;

  irq_ack_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_in    (ack_in),
    .ack_first (ack_first),
    .ack_last  (ack_last)
  );

  assign chain[0] = ack_in;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    localparam logic [VEC_W-1:0] VEC_I = VEC_W'(cell_vector(VEC_BASE, i));
    irq_cell #(
      .VEC_W    (VEC_W),
      .CELL_VEC (VEC_I)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_set   (dev_req[i]),
      .ack_first (ack_first),
      .ack_last  (ack_last),
      .ack_in    (chain[i]),
      .ack_out   (chain[i+1]),
      .req_out   (pend[i]),
      .vec_out   (cell_vec[i])
    );
  end

  assign irq_out = |pend;

  irq_vec_merge #(
    .N_CELLS (N_CELLS),
    .VEC_W   (VEC_W)
  ) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cell_vec (cell_vec),
    .tail_ack (chain[N_CELLS]),
    .vec_q    (vec_out),
    .spur_q   (spurious_out)
  );
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
  parameter int unsigned N_CELLS = 8,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CELLS-1:0] dev_req,
  input logic               irq_out,
  input logic               ack_in,
  input logic [VEC_W-1:0]   vec_out,
  input logic               spurious_out
);
  // R8: an idle acknowledge yields an empty vector and no spurious flag
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_in |=> (vec_out == '0 && !spurious_out));

  // R8: spurious and a real vector never coexist
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(spurious_out && vec_out != '0));

  // R2: any request pulse raises the shared line at the next edge
  a_r2_line_up: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_req) |=> irq_out);

  // R3: an acknowledge met by a raised line is claimed
  a_r3_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !$past(ack_in) && irq_out) |=> (vec_out != '0));

  // R6: an acknowledge with the line low runs off the end of the chain
  a_r6_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !$past(ack_in) && !irq_out) |=> spurious_out);

  // R4: outputs frozen while acknowledge is held
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && $past(ack_in)) |=> ($stable(vec_out) && $stable(spurious_out)));
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(
  .N_CELLS (N_CELLS),
  .VEC_W   (VEC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dev_req      (dev_req),
  .irq_out      (irq_out),
  .ack_in       (ack_in),
  .vec_out      (vec_out),
  .spurious_out (spurious_out)
);

// File: tb/irq_daisy_chain_bench.sv
`timescale 1ns/1ps
module irq_daisy_chain_bench;
  localparam int N    = 8;
  localparam int VW   = 8;
  localparam int BASE = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_req = '0;
  logic          ack_in = 1'b0;
  logic          irq_out;
  logic [VW-1:0] vec_out;
  logic          spurious_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [N-1:0] m_pend = '0;
  logic         m_ackq = 1'b0;
  int           m_cur  = -1;

  always #2 clk = ~clk;

  irq_daisy_chain #(.N_CELLS(N), .VEC_W(VW), .VEC_BASE(BASE)) u_irq_daisy_chain (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .irq_out(irq_out),
    .ack_in(ack_in), .vec_out(vec_out), .spurious_out(spurious_out)
  );

  function automatic int lowest(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, advance model at posedge, check after it.
  task automatic step(input logic [N-1:0] req, input logic ack, input string tag);
    logic first, last;
    int   exp_vec;
    logic exp_spur;
    string vt;
    @(negedge clk);
    dev_req = req;
    ack_in  = ack;
    @(posedge clk);
    first = ack & ~m_ackq;
    last  = ~ack & m_ackq;
    if (first) m_cur = lowest(m_pend);
    exp_vec  = (ack && m_cur >= 0) ? BASE + m_cur : 0;
    exp_spur = ack && m_cur < 0;
    if (last && m_cur >= 0 && !req[m_cur]) m_pend[m_cur] = 1'b0;
    m_pend = m_pend | req;
    if (last) m_cur = -1;
    m_ackq = ack;
    vt = (tag != "") ? tag : (!ack ? "R8" : (exp_spur ? "R6" : (first ? "R3" : "R4")));
    #1;
    check({vt, " vector"}, int'(vec_out), exp_vec);
    check({vt, " spurious"}, int'(spurious_out), int'(exp_spur));
    check((tag != "") ? tag : "R2", int'(irq_out), int'(|m_pend));
  endtask

  // Acknowledge held for len cycles, then released.
  task automatic acknowledge(input int len);
    for (int i = 0; i < len; i++) step('0, 1'b1, "");
    step('0, 1'b0, "R5");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    check("R1 vector", int'(vec_out), 0);
    check("R1 spurious", int'(spurious_out), 0);
    check("R1 irq", int'(irq_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step('0, 1'b0, "R1");

    // R6: acknowledge with nothing pending
    acknowledge(3);

    // R3/R5: all pending, served strictly in chain order
    step('1, 1'b0, "R2");
    for (int k = 0; k < N; k++) begin
      step('0, 1'b1, "");
      check("R3 order", int'(vec_out), BASE + k);
      step('0, 1'b0, "R5");
    end
    check("R5 drained", int'(irq_out), 0);

    // Only the last cell requests
    step(N'(1) << (N - 1), 1'b0, "R2");
    acknowledge(2);

    // R4: higher-priority request arrives mid-acknowledge
    step(N'(1) << 5, 1'b0, "R2");
    step('0, 1'b1, "");
    step(N'(1), 1'b1, "R4");
    step('0, 1'b1, "");
    check("R4 keeps winner", int'(vec_out), BASE + 5);
    step('0, 1'b0, "R5");
    acknowledge(1);
    check("R5 cleared", int'(irq_out), 0);

    // R7: re-request on the clearing cycle keeps the cell pending
    step(N'(1) << 2, 1'b0, "R2");
    step('0, 1'b1, "");
    step(N'(1) << 2, 1'b0, "R7");
    check("R7 still pending", int'(irq_out), 1);
    step('0, 1'b1, "");
    check("R7 served again", int'(vec_out), BASE + 2);
    step('0, 1'b0, "R5");

    // Constrained random traffic
    for (int t = 0; t < 3000; t++) begin
      logic [N-1:0] r;
      r = ($urandom_range(0, 3) == 0) ? N'($urandom()) & N'($urandom()) : '0;
      if ($urandom_range(0, 5) == 0) begin
        int len;
        len = $urandom_range(1, 4);
        for (int i = 0; i < len; i++) step((i == 1) ? r : '0, 1'b1, "");
        step(r, 1'b0, "");
      end else begin
        step(r, 1'b0, "");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule